// File: doc/BRIEF.md
# Multichannel Configurable SPI Master

This block is a synchronous serial master with four active-low select lines. Each select line is a channel with its own stored settings: serial clock rate, clock polarity, clock phase, word length from 4 to 32 bits, transfer direction and a lead time between select assertion and the first serial clock edge. A host writes a channel's settings through a small configuration port. It then names a channel, supplies a transmit word and pulses `start`. The block asserts that channel's select line, waits out the lead time and shifts the word most significant bit first. It finishes with a one-cycle `done` pulse and, when the channel receives, the right-aligned received word.

Full-duplex operation uses the transmit-and-receive direction. Half-duplex links use the transmit-only or receive-only direction. A transfer works from a private copy of the channel settings taken at start, so rewriting settings while a transfer runs affects only later transfers.

Top module: `spim_master`

## Requirements
- R1: `cs_n` has one bit per channel, active low. During a transfer only the bit of the channel named at start is low. All bits are high when idle.
- R2: Settings are stored per channel and written by `cfg_we` with `cfg_ch`. `cfg_wdata` packs the fields as follows: bits [2:0] divider code D, bit 3 clock polarity, bit 4 clock phase, bits [9:5] length code L, bits [11:10] direction, bits [19:12] lead count. A write takes effect for transfers started after it, and no other channel changes.
- R3: The serial clock toggles every 2^D system clocks (divide by 2 for D=0 up to divide by 256 for D=7). Between transfers and during the lead time it rests at the polarity of the channel.
- R4: Data is shifted MSB first. Phase 0 samples `miso` on leading clock edges and changes `mosi` on trailing edges, with the first bit driven before the first edge. Phase 1 changes `mosi` on leading edges and samples on trailing edges, and `mosi` stays low until the first leading edge.
- R5: A word is L+1 bits long, and codes below 3 act as 3 (4 bits). The transmit word uses its low L+1 bits. The received word is right-aligned with zeros above it, and the serial clock makes 2·(L+1) edges per word.
- R6: With lead count C, the first transmit bit (phase 0) appears C+1 system clocks after the select line falls. The first serial clock edge follows 2^D system clocks later.
- R7: Direction 1 (transmit only) drives data but raises no `rx_valid` and leaves `rx_word` unchanged. `rx_valid` is only ever high together with `done`.
- R8: Direction 2 (receive only) holds `mosi` low for the whole transfer and delivers the received word with `rx_valid`. Directions 0 and 3 transmit and receive.
- R9: `done` is high for exactly one system clock, in the cycle after the last bit is sampled. The select line rises 2^D system clocks after that sampling edge, and the serial clock returns to the channel polarity at the same moment.
- R10: `busy` is high from the clock after an accepted `start` until the select line is released. A `start` seen while `busy` is high is ignored.
- R11: While idle, the serial clock follows, one clock later, the polarity stored for the channel named on `ch_sel`.
- R12: After reset every select is high, and `sclk`, `mosi`, `busy`, `done`, `rx_valid` and `rx_word` are zero. All channel settings reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for channel settings |
| cfg_ch | input | CH_W | Channel whose settings are written |
| cfg_wdata | input | 20 | Packed settings (layout in R2) |
| start | input | 1 | Begin a transfer on `ch_sel` |
| ch_sel | input | CH_W | Channel for the next transfer and for the idle clock level |
| tx_word | input | 32 | Word to transmit, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_valid | output | 1 | `rx_word` was updated this cycle |
| rx_word | output | 32 | Last received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCH | Active-low chip selects |

## Verification
The four channels are set to different combinations of divider, polarity, phase, length, direction and lead, so each of the four clock modes is seen. Each mode is run with contrasting words: alternating bits, all ones, a single set bit and a length code below the minimum. A mismatch in edge placement, bit order or word length therefore shows up as a wrong `mosi` or `rx_word` in a specific cycle. `miso` changes every system clock from a hashed cycle count, so sampling on the wrong edge or one clock early or late gives a different received word. Separate runs cover a start pulse on another channel during a long transfer, back-to-back transfers, the slowest divider, and idle clock level changes on `ch_sel`.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int SPIM_DIV_W    = 3;
  localparam int SPIM_LEN_W    = 5;
  localparam int SPIM_LEAD_W   = 8;
  localparam int SPIM_MAX_BITS = 1 << SPIM_LEN_W;
  localparam int SPIM_MIN_BITS = 4;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_TXONLY = 2'd1,
    XM_RXONLY = 2'd2,
    XM_SPARE  = 2'd3
  } xfer_mode_e;

  // Packed MSB first: lead [19:12], mode [11:10], len [9:5], cpha [4], cpol [3], div [2:0]
  typedef struct packed {
    logic [SPIM_LEAD_W-1:0] lead;
    xfer_mode_e             mode;
    logic [SPIM_LEN_W-1:0]  len;
    logic                   cpha;
    logic                   cpol;
    logic [SPIM_DIV_W-1:0]  div;
  } chan_cfg_t;

  localparam int SPIM_CFG_W = $bits(chan_cfg_t);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL} eng_state_e;
endpackage

// File: rtl/spim_cfg_bank.sv
module spim_cfg_bank
  import spim_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  chan_cfg_t       wr_cfg,
  input  logic [CH_W-1:0] rd_ch,
  output chan_cfg_t       rd_cfg
);
  chan_cfg_t bank [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_cfg_t cfg_q;
    always_ff @(posedge clk) begin
      if (rst) cfg_q <= '0;
      else if (wr_en && wr_ch == CH_W'(g)) cfg_q <= wr_cfg;
    end
    assign bank[g] = cfg_q;
  end

  assign rd_cfg = bank[rd_ch];
endmodule

// File: rtl/spim_halfper.sv
module spim_halfper #(
  parameter int DIV_W = 3,
  parameter int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = CNT_W'((1 << div) - 1);
  assign tick   = run && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= reload;
    else if (run)     cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end

  // R3: the half-period counter never exceeds the selected ratio
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= reload));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH),
  parameter int DW   = SPIM_MAX_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [CH_W-1:0] ch_sel,
  input  chan_cfg_t       sel_cfg,
  input  logic [DW-1:0]   tx_word,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic            rx_valid,
  output logic [NCH-1:0]  cs_n,
  output logic [DW-1:0]   rx_word
);
  localparam int EC_W = SPIM_LEN_W + 1;
  localparam logic [SPIM_LEN_W-1:0] MIN_LEN = SPIM_LEN_W'(SPIM_MIN_BITS - 1);
  localparam logic [SPIM_LEN_W-1:0] TOP_BIT = SPIM_LEN_W'(DW - 1);

  eng_state_e              state;
  chan_cfg_t               act;
  chan_cfg_t               sel_fix;
  logic [DW-1:0]           tx_sh, rx_sh;
  logic [EC_W-1:0]         ecnt;
  logic [SPIM_LEAD_W-1:0]  lead_cnt;
  logic [SPIM_LEN_W-1:0]   len_eff, pad;
  logic hp_tick, hp_restart, hp_run, tx_en, rx_en, smp_edge, last_edge;

  assign len_eff = (sel_cfg.len < MIN_LEN) ? MIN_LEN : sel_cfg.len;
  assign pad     = TOP_BIT - len_eff;
  always_comb begin
    sel_fix     = sel_cfg;
    sel_fix.len = len_eff;
  end

  assign tx_en      = act.mode != XM_RXONLY;
  assign rx_en      = act.mode != XM_TXONLY;
  assign smp_edge   = ecnt[0] == act.cpha;
  assign last_edge  = ecnt == {act.len, act.cpha};
  assign hp_restart = (state == ST_LEAD) && (lead_cnt == '0);
  assign hp_run     = (state == ST_SHIFT) || (state == ST_TAIL);

  spim_halfper #(.DIV_W(SPIM_DIV_W)) u_half (
    .clk(clk), .rst(rst), .restart(hp_restart), .run(hp_run),
    .div(act.div), .tick(hp_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  act <= '0;  tx_sh <= '0;  rx_sh <= '0;
      ecnt <= '0;  lead_cnt <= '0;  sclk <= 1'b0;  mosi <= 1'b0;
      busy <= 1'b0;  done <= 1'b0;  rx_valid <= 1'b0;
      cs_n <= '1;  rx_word <= '0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk <= sel_cfg.cpol;
          if (start) begin
            act      <= sel_fix;
            cs_n     <= ~(NCH'(1) << ch_sel);
            busy     <= 1'b1;
            tx_sh    <= tx_word << pad;
            rx_sh    <= '0;
            ecnt     <= '0;
            lead_cnt <= sel_cfg.lead;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (lead_cnt == '0) begin
            state <= ST_SHIFT;
            if (!act.cpha && tx_en) begin
              mosi  <= tx_sh[DW-1];
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end else begin
            lead_cnt <= lead_cnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (hp_tick) begin
            sclk <= ~sclk;
            ecnt <= ecnt + 1'b1;
            if (smp_edge) begin
              rx_sh <= {rx_sh[DW-2:0], miso};
              if (last_edge) begin
                state <= ST_TAIL;
                done  <= 1'b1;
                if (rx_en) begin
                  rx_valid <= 1'b1;
                  rx_word  <= {rx_sh[DW-2:0], miso};
                end
              end
            end else if (tx_en) begin
              mosi  <= tx_sh[DW-1];
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end
        end
        ST_TAIL: begin
          if (hp_tick) begin
            sclk  <= act.cpol;
            mosi  <= 1'b0;
            cs_n  <= '1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_one_select_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  assert_busy_matches_select_R10: assert property (@(posedge clk) disable iff (rst)
    busy == (cs_n != '1));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cs_n == $past(cs_n)) || (cs_n == '1));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_while_selected_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n != '1));
  assert_rx_valid_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> done);
  assert_rx_only_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && act.mode == XM_RXONLY) |-> !mosi);
  assert_lead_clock_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEAD) |-> (sclk == act.cpol));
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [SPIM_CFG_W-1:0]    cfg_wdata,
  input  logic                     start,
  input  logic [CH_W-1:0]          ch_sel,
  input  logic [SPIM_MAX_BITS-1:0] tx_word,
  output logic                     busy,
  output logic                     done,
  output logic                     rx_valid,
  output logic [SPIM_MAX_BITS-1:0] rx_word,
  output logic                     sclk,
  output logic                     mosi,
  input  logic                     miso,
  output logic [NCH-1:0]           cs_n
);
  chan_cfg_t sel_cfg;

  spim_cfg_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_ch(cfg_ch),
    .wr_cfg(chan_cfg_t'(cfg_wdata)), .rd_ch(ch_sel), .rd_cfg(sel_cfg)
  );

  spim_engine #(.NCH(NCH), .CH_W(CH_W), .DW(SPIM_MAX_BITS)) u_eng (
    .clk(clk), .rst(rst), .start(start), .ch_sel(ch_sel), .sel_cfg(sel_cfg),
    .tx_word(tx_word), .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
    .done(done), .rx_valid(rx_valid), .cs_n(cs_n), .rx_word(rx_word)
  );
endmodule

// File: tb/tb_spim_master.sv
`timescale 1ns/1ps
module tb_spim_master;
  import spim_pkg::*;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);
  localparam int DW  = SPIM_MAX_BITS;

  logic clk = 1'b0, rst = 1'b1, cfg_we = 1'b0, start = 1'b0, miso = 1'b0;
  logic [CW-1:0] cfg_ch = '0, ch_sel = '0;
  logic [SPIM_CFG_W-1:0] cfg_wdata = '0;
  logic [DW-1:0] tx_word = '0;
  logic busy, done, rx_valid, sclk, mosi;
  logic [DW-1:0] rx_word;
  logic [NCH-1:0] cs_n;

  always #2 clk = ~clk;

  spim_master #(.NCH(NCH)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_wdata(cfg_wdata),
    .start(start), .ch_sel(ch_sel), .tx_word(tx_word), .busy(busy), .done(done),
    .rx_valid(rx_valid), .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  typedef struct {
    int at; logic [NCH-1:0] cs_n; logic sclk, mosi, busy, done, rxv; logic [DW-1:0] rxw;
  } exp_t;

  exp_t expq[$];
  logic [SPIM_CFG_W-1:0] shadow [NCH];
  int cyc = 0, checks = 0, errors = 0;
  logic idle_sclk = 1'b0;
  logic [DW-1:0] exp_rxw = '0;
  bit finished = 0;

  function automatic logic miso_at(int c);
    logic [31:0] h;
    h = 32'(c) * 32'h9E37_79B1;
    return h[17] ^ h[9];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < NCH; i++) shadow[i] <= '0;
      idle_sclk <= 1'b0;
    end else begin
      if (cfg_we) shadow[cfg_ch] <= cfg_wdata;
      idle_sclk <= shadow[ch_sel][3];
    end
  end

  always @(posedge clk) begin
    #1 miso = miso_at(cyc);
  end

  // Reference timeline for one transfer, one entry per system clock from the start edge
  task automatic build(int ch, logic [DW-1:0] w);
    chan_cfg_t c = chan_cfg_t'(shadow[ch]);
    int h = 1 << c.div;
    int n = ((int'(c.len) < 3) ? 3 : int'(c.len)) + 1;
    int x = int'(c.lead) + 1;
    int kl = c.cpha ? 2 * n - 1 : 2 * n - 2;
    int r = x + (kl + 1) * h + h;
    int s0 = cyc + 1;
    bit txe = (c.mode != XM_RXONLY);
    bit rxe = (c.mode != XM_TXONLY);
    logic s = c.cpol, m = 1'b0;
    int idx = n - 1, k = 0;
    logic [DW-1:0] acc = '0;
    for (int t = 0; t <= r; t++) begin
      exp_t e;
      e.at = s0 + t; e.cs_n = '1; e.cs_n[ch] = 1'b0; e.busy = 1'b1;
      e.done = 1'b0; e.rxv = 1'b0; e.rxw = '0;
      if (t == x && !c.cpha && txe) begin m = w[idx]; idx--; end
      if (t > x && ((t - x) % h) == 0 && k <= kl) begin
        s = ~s;
        if ((k % 2) == int'(c.cpha)) begin
          acc = {acc[DW-2:0], miso_at(s0 + t - 1)};
          if (k == kl) begin e.done = 1'b1; e.rxv = rxe; e.rxw = acc; end
        end else if (txe) begin
          m = w[idx]; idx--;
        end
        k++;
      end
      if (t == r) begin e.cs_n = '1; e.busy = 1'b0; s = c.cpol; m = 1'b0; end
      e.sclk = s; e.mosi = m;
      expq.push_back(e);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      exp_t e;
      bit idle;
      idle = 1;
      e.cs_n = '1; e.sclk = idle_sclk; e.mosi = 1'b0; e.busy = 1'b0;
      e.done = 1'b0; e.rxv = 1'b0; e.rxw = '0;
      if (expq.size() > 0 && expq[0].at == cyc) begin e = expq.pop_front(); idle = 0; end
      if (e.rxv) exp_rxw = e.rxw;
      checks++;
      if (cs_n !== e.cs_n) begin errors++;
        $display("FAIL R1 cyc %0d cs_n actual %b expected %b", cyc, cs_n, e.cs_n); end
      if (sclk !== e.sclk) begin errors++;
        if (idle) $display("FAIL R11 cyc %0d idle sclk actual %b expected %b", cyc, sclk, e.sclk);
        else $display("FAIL R3 R4 R6 cyc %0d sclk actual %b expected %b", cyc, sclk, e.sclk); end
      if (mosi !== e.mosi) begin errors++;
        $display("FAIL R4 R8 cyc %0d mosi actual %b expected %b", cyc, mosi, e.mosi); end
      if (busy !== e.busy) begin errors++;
        $display("FAIL R10 cyc %0d busy actual %b expected %b", cyc, busy, e.busy); end
      if (done !== e.done) begin errors++;
        $display("FAIL R9 cyc %0d done actual %b expected %b", cyc, done, e.done); end
      if (rx_valid !== e.rxv) begin errors++;
        $display("FAIL R7 cyc %0d rx_valid actual %b expected %b", cyc, rx_valid, e.rxv); end
      if (rx_word !== exp_rxw) begin errors++;
        $display("FAIL R5 cyc %0d rx_word actual %h expected %h", cyc, rx_word, exp_rxw); end
    end
  end

  task automatic wcfg(int ch, int lead, int mode, int len, bit cpha, bit cpol, int dv);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_ch = CW'(ch);
    cfg_wdata = {8'(lead), 2'(mode), 5'(len), cpha, cpol, 3'(dv)};
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic xfer(int ch, logic [DW-1:0] w, int poke);
    chan_cfg_t c = chan_cfg_t'(shadow[ch]);
    int n = ((int'(c.len) < 3) ? 3 : int'(c.len)) + 1;
    int tog = 0;
    bit stray = 0;
    logic prev;
    int alt = (ch + 1) % NCH;
    @(posedge clk); #1;
    ch_sel = CW'(ch); tx_word = w; start = 1'b1;
    build(ch, w);
    @(posedge clk); #1;
    start = 1'b0;
    if (poke > 0) begin
      fork
        begin
          repeat (poke) @(posedge clk);
          #1 start = 1'b1; ch_sel = CW'(alt); tx_word = ~w;
          @(posedge clk);
          #1 start = 1'b0; ch_sel = CW'(ch);
        end
      join_none
    end
    @(negedge clk);
    prev = sclk;
    while (busy) begin
      @(negedge clk);
      if (sclk !== prev) tog++;
      prev = sclk;
      if (cs_n[alt] !== 1'b1) stray = 1;
    end
    checks++;
    if (tog != 2 * n) begin errors++;
      $display("FAIL R2 R5 ch %0d clock edges actual %0d expected %0d", ch, tog, 2 * n); end
    checks++;
    if (stray) begin errors++;
      $display("FAIL R1 R10 ch %0d select %0d actual low expected high", ch, alt); end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual still running, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++; // R12 reset state
    if (cs_n !== '1 || sclk !== 1'b0 || mosi !== 1'b0 || busy !== 1'b0 ||
        done !== 1'b0 || rx_valid !== 1'b0 || rx_word !== '0) begin
      errors++;
      $display("FAIL R12 reset outputs actual cs_n %b sclk %b mosi %b busy %b done %b rxv %b rxw %h expected all idle",
               cs_n, sclk, mosi, busy, done, rx_valid, rx_word);
    end
    // R2: distinct settings per channel (lead, mode, len, cpha, cpol, div)
    wcfg(0, 0, 0, 7,  1'b0, 1'b0, 0);
    wcfg(1, 3, 1, 15, 1'b0, 1'b1, 1);
    wcfg(2, 5, 2, 31, 1'b1, 1'b0, 2);
    wcfg(3, 2, 0, 1,  1'b1, 1'b1, 0);
    repeat (2) @(posedge clk);
    xfer(0, 32'h0000_00A5, 0);            // R4 mode 0 duplex
    xfer(0, 32'h0000_003C, 0);
    xfer(1, 32'h0000_BEEF, 0);            // R7 transmit only, mode 2
    xfer(2, 32'hFFFF_FFFF, 12);           // R8 receive only, R10 ignored start
    xfer(3, 32'h0000_000B, 0);            // R5 clamped length, mode 3
    xfer(3, 32'h0000_0004, 0);
    // R11 idle clock level follows the selected channel
    @(posedge clk); #1 ch_sel = CW'(1);
    repeat (3) @(negedge clk);
    checks++;
    if (sclk !== 1'b1) begin errors++;
      $display("FAIL R11 idle sclk on ch1 actual %b expected 1", sclk); end
    @(posedge clk); #1 ch_sel = CW'(2);
    repeat (3) @(negedge clk);
    checks++;
    if (sclk !== 1'b0) begin errors++;
      $display("FAIL R11 idle sclk on ch2 actual %b expected 0", sclk); end
    // R3 slowest divider, R6 zero lead, direction code 3 acts as duplex
    wcfg(0, 0, 3, 3, 1'b1, 1'b0, 7);
    xfer(0, 32'h0000_0009, 0);
    wcfg(1, 0, 0, 31, 1'b1, 1'b1, 0);
    xfer(1, 32'h8000_0001, 0);
    // R9 R10 back-to-back words
    xfer(3, 32'h0000_000F, 0);
    xfer(3, 32'h0000_0000, 0);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule